// File: doc/BRIEF.md
# Multi-drop Addressed-Frame UART Receiver

This block receives asynchronous serial frames on a shared multi-drop line where every frame carries a ninth "address" bit after its eight data bits. A set address bit marks a station-address frame and a clear one marks a payload frame. There is no parity bit. The bit clock is a 16x oversampling tick. Each bit is sampled once, at the middle of the bit.

Host software can arm a skip mode. While skip mode is armed, payload frames pass without effect. The buffer, the address-bit output, the ready flag and both error flags all stay as they were. When an address frame arrives, it is accepted normally and the hardware disarms skip mode. The host then reads the address byte, compares it with its own station number, and re-arms skip mode if the frame was meant for another station.

A small transmitter is included. It sends the same frame shape with an address bit chosen by the caller, for example station 01h followed by payload AAh.

Top module: `mpb_uart`

## Requirements
- R1: The frame is laid out in this order: one low start bit, eight data bits with the LSB first, one address bit, and one high stop bit. Each bit lasts 16 `baud_tick` pulses, and the line idles high. The receiver samples each bit near its midpoint.
- R2: When skip mode is off, every completed frame is stored. `rx_byte` takes the data bits and `rx_addr_flag` takes the received address bit (0 or 1). `rx_ready` goes to 1 once the stop bit has been sampled.
- R3: While `skip_en` is 1, a frame whose address bit is 0 leaves five outputs unchanged: `rx_byte`, `rx_addr_flag`, `rx_ready`, `err_frame` and `err_overrun`. This holds even if that frame's stop bit is low.
- R4: A frame whose address bit is 1 is always accepted. It sets `rx_addr_flag` to 1 and clears `skip_en`. Payload frames that follow are then received normally.
- R5: A one-cycle `skip_set` pulse sets `skip_en` to 1. If an address frame completes in the same cycle, the hardware clear wins.
- R6: For an accepted frame, `err_frame` shows whether the stop bit was sampled low (1) or high (0). The flag is replaced on every accepted frame.
- R7: If a frame is accepted while `rx_ready` is still 1 and no read happens in that cycle, `err_overrun` is set and the newer frame overwrites the buffer. A `rd_strobe` clears both `rx_ready` and `err_overrun`.
- R8: A low pulse on the line that has gone high again by the middle of the start bit is discarded. No frame is stored and no flag changes.
- R9: A `tx_start` pulse while the transmitter is idle sends `tx_byte` and `tx_addr_flag` in the R1 frame layout on `txd`. `tx_busy` is high for the 11 bit times, and `txd` is high whenever the transmitter is idle.
- R10: After reset, `rx_ready`, `err_frame`, `err_overrun`, `skip_en` and `tx_busy` are 0, and `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial receive line |
| skip_set | input | 1 | Pulse that arms skip mode |
| rd_strobe | input | 1 | Pulse that marks the received byte as read |
| tx_start | input | 1 | Pulse that starts a transmission |
| tx_byte | input | 8 | Data byte to transmit |
| tx_addr_flag | input | 1 | Address bit to transmit |
| rx_byte | output | 8 | Last accepted data byte |
| rx_addr_flag | output | 1 | Address bit of the last accepted frame |
| rx_ready | output | 1 | An accepted frame is waiting to be read |
| err_frame | output | 1 | Stop bit of the last accepted frame was low |
| err_overrun | output | 1 | A frame was accepted while the previous one was unread |
| skip_en | output | 1 | Skip mode armed |
| txd | output | 1 | Serial transmit line |
| tx_busy | output | 1 | Transmitter is sending a frame |

## Verification
Suppose the skip flag is wrong, either stuck armed or cleared too early. The ports show it within one frame time: payload bytes either fail to appear in `rx_byte` or appear while they should be hidden. A receiver that has slipped its bit position shows a shifted byte, or a low stop sample with `err_frame` raised, on the first frame after the fault. An overrun or ready flag that is mis-held shows at the next read or the next accepted frame. Looping the transmitter back into the receiver also exposes a wrong frame order or a wrong bit count in a single frame.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_e;

  // total bits on the line: start + data + address + stop
  function automatic int unsigned frame_bits(int unsigned data_bits);
    return data_bits + 3;
  endfunction

  // tick index inside the start bit where the midpoint is sampled
  function automatic int unsigned mid_tick(int unsigned ovs);
    return ovs / 2 - 1;
  endfunction

  // overrun rule: buffer still full and not being read this cycle
  function automatic logic overrun_next(logic ready, logic rd);
    return ready & ~rd;
  endfunction
endpackage

// File: rtl/mpb_rx_deser.sv
module mpb_rx_deser
  import mpb_pkg::*;
#(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          rxd,
  output logic          frame_done,
  output logic [DW-1:0] frame_data,
  output logic          frame_mp,
  output logic          frame_stop_ok,
  output logic          glitch
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned MID = mid_tick(OVS);
  localparam int unsigned NB  = DW + 1;
  localparam int unsigned BW  = $clog2(NB + 1);

  logic [1:0]    sync_q;
  logic          rx_s;
  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [NB-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end
  assign rx_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= RX_IDLE;
      cnt           <= '0;
      bitn          <= '0;
      shreg         <= '0;
      frame_done    <= 1'b0;
      frame_stop_ok <= 1'b0;
      glitch        <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      glitch     <= 1'b0;
      if (baud_tick) begin
        case (state)
          RX_IDLE: begin
            if (!rx_s) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt == CW'(MID)) begin
              cnt  <= '0;
              bitn <= '0;
              if (!rx_s) state <= RX_BITS;
              else begin
                state  <= RX_IDLE;
                glitch <= 1'b1;
              end
            end else cnt <= cnt + 1'b1;
          end
          RX_BITS: begin
            if (cnt == CW'(OVS - 1)) begin
              cnt   <= '0;
              shreg <= {rx_s, shreg[NB-1:1]};
              if (bitn == BW'(NB - 1)) state <= RX_STOP;
              bitn <= bitn + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          RX_STOP: begin
            if (cnt == CW'(OVS - 1)) begin
              cnt           <= '0;
              state         <= RX_IDLE;
              frame_done    <= 1'b1;
              frame_stop_ok <= rx_s;
            end else cnt <= cnt + 1'b1;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign frame_data = shreg[DW-1:0];
  assign frame_mp   = shreg[DW];

  // R1: a completed frame is reported for exactly one cycle
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R8: an aborted start never coincides with a frame completion
  assert_glitch_no_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    glitch |=> !frame_done);
endmodule

// File: rtl/mpb_rx_buffer.sv
module mpb_rx_buffer
  import mpb_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_done,
  input  logic [DW-1:0] frame_data,
  input  logic          frame_mp,
  input  logic          frame_stop_ok,
  input  logic          glitch,
  input  logic          skip_set,
  input  logic          rd_strobe,
  output logic [DW-1:0] rx_byte,
  output logic          rx_addr_flag,
  output logic          rx_ready,
  output logic          err_frame,
  output logic          err_overrun,
  output logic          skip_en
);
  logic accept;
  logic id_seen;

  assign id_seen = frame_done & frame_mp;
  assign accept  = frame_done & (~skip_en | frame_mp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        skip_en <= 1'b0;
    else if (id_seen)  skip_en <= 1'b0;
    else if (skip_set) skip_en <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte      <= '0;
      rx_addr_flag <= 1'b0;
      rx_ready     <= 1'b0;
      err_frame    <= 1'b0;
      err_overrun  <= 1'b0;
    end else if (accept) begin
      rx_byte      <= frame_data;
      rx_addr_flag <= frame_mp;
      rx_ready     <= 1'b1;
      err_frame    <= ~frame_stop_ok;
      err_overrun  <= overrun_next(rx_ready, rd_strobe);
    end else if (rd_strobe) begin
      rx_ready    <= 1'b0;
      err_overrun <= 1'b0;
    end
  end

  // R3: a hidden payload frame changes none of the stored results
  assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && skip_en && !frame_mp) |=>
      ($stable(rx_byte) && $stable(rx_addr_flag) && $stable(err_frame)));

  // R4: an address frame leaves skip disarmed and the address flag set
  assert_id_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_mp) |=> (!skip_en && rx_addr_flag));

  // R5: arming sticks unless an address frame lands in the same cycle
  assert_arm_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_set && !(frame_done && frame_mp)) |=> skip_en);

  // R2: an accepted frame always leaves the ready flag up
  assert_ready_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !skip_en) |=> rx_ready);

  // R7: overrun only rises while an unread frame was pending
  assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(rx_ready));

  // R8: an aborted start leaves the buffer and framing flag alone
  assert_glitch_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    glitch |=> ($stable(rx_byte) && $stable(err_frame)));
endmodule

// File: rtl/mpb_tx_ser.sv
module mpb_tx_ser
  import mpb_pkg::*;
#(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          tx_start,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_mp,
  output logic          txd,
  output logic          tx_busy
);
  localparam int unsigned FB = frame_bits(DW);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned BW = $clog2(FB + 1);

  logic [FB-1:0] shreg;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '1;
      cnt     <= '0;
      bitn    <= '0;
      tx_busy <= 1'b0;
    end else if (!tx_busy && tx_start) begin
      shreg   <= {1'b1, tx_mp, tx_data, 1'b0};
      cnt     <= '0;
      bitn    <= '0;
      tx_busy <= 1'b1;
    end else if (tx_busy && baud_tick) begin
      if (cnt == CW'(OVS - 1)) begin
        cnt   <= '0;
        shreg <= {1'b1, shreg[FB-1:1]};
        if (bitn == BW'(FB - 1)) tx_busy <= 1'b0;
        bitn <= bitn + 1'b1;
      end else cnt <= cnt + 1'b1;
    end
  end

  assign txd = tx_busy ? shreg[0] : 1'b1;

  // R9: an accepted start request begins with the low start bit
  assert_tx_start_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !tx_busy) |=> (tx_busy && !txd));
endmodule

// File: rtl/mpb_uart.sv
module mpb_uart
  import mpb_pkg::*;
#(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          rxd,
  input  logic          skip_set,
  input  logic          rd_strobe,
  input  logic          tx_start,
  input  logic [DW-1:0] tx_byte,
  input  logic          tx_addr_flag,
  output logic [DW-1:0] rx_byte,
  output logic          rx_addr_flag,
  output logic          rx_ready,
  output logic          err_frame,
  output logic          err_overrun,
  output logic          skip_en,
  output logic          txd,
  output logic          tx_busy
);
  logic          frame_done;
  logic [DW-1:0] frame_data;
  logic          frame_mp;
  logic          frame_stop_ok;
  logic          glitch;

  mpb_rx_deser #(.OVS(OVS), .DW(DW)) u_deser (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .frame_done(frame_done), .frame_data(frame_data), .frame_mp(frame_mp),
    .frame_stop_ok(frame_stop_ok), .glitch(glitch)
  );

  mpb_rx_buffer #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_data(frame_data),
    .frame_mp(frame_mp), .frame_stop_ok(frame_stop_ok), .glitch(glitch),
    .skip_set(skip_set), .rd_strobe(rd_strobe), .rx_byte(rx_byte),
    .rx_addr_flag(rx_addr_flag), .rx_ready(rx_ready), .err_frame(err_frame),
    .err_overrun(err_overrun), .skip_en(skip_en)
  );

  mpb_tx_ser #(.OVS(OVS), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_start(tx_start),
    .tx_data(tx_byte), .tx_mp(tx_addr_flag), .txd(txd), .tx_busy(tx_busy)
  );
endmodule

// File: tb/mpb_uart_test.sv
module mpb_uart_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div = 2'd0;
  logic       baud_tick;
  logic       line = 1'b1;
  logic       loop = 1'b0;
  logic       rxd;
  logic       skip_set = 1'b0, rd_strobe = 1'b0, tx_start = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       tx_addr_flag = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_addr_flag, rx_ready, err_frame, err_overrun, skip_en, txd, tx_busy;
  int         checks = 0, fails = 0;
  bit         done_flag = 1'b0;

  localparam int BITCLK = 64; // 16 ticks x 4 clocks

  always #10 clk = ~clk;
  always @(posedge clk) div <= div + 2'd1;
  assign baud_tick = (div == 2'd3);
  assign rxd = loop ? txd : line;

  mpb_uart uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .skip_set(skip_set), .rd_strobe(rd_strobe), .tx_start(tx_start),
    .tx_byte(tx_byte), .tx_addr_flag(tx_addr_flag), .rx_byte(rx_byte),
    .rx_addr_flag(rx_addr_flag), .rx_ready(rx_ready), .err_frame(err_frame),
    .err_overrun(err_overrun), .skip_en(skip_en), .txd(txd), .tx_busy(tx_busy)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  task automatic send_frame(logic [7:0] d, logic mp, logic stop);
    logic [10:0] bits;
    bits = {stop, mp, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      line = bits[i];
      repeat (BITCLK) @(negedge clk);
    end
    line = 1'b1;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic pulse_rd();
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_skip();
    skip_set = 1'b1; @(negedge clk); skip_set = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 rx_ready", rx_ready, 0);
    check("R10 err_frame", err_frame, 0);
    check("R10 err_overrun", err_overrun, 0);
    check("R10 skip_en", skip_en, 0);
    check("R10 tx_busy", tx_busy, 0);
    check("R10 txd", txd, 1);
  endtask

  task automatic t_normal();
    send_frame(8'h5A, 1'b0, 1'b1);
    check("R1 byte 5A", rx_byte, 8'h5A);
    check("R2 mp 0", rx_addr_flag, 0);
    check("R2 ready", rx_ready, 1);
    check("R6 no frame err", err_frame, 0);
    pulse_rd();
    check("R7 read clears ready", rx_ready, 0);
    send_frame(8'hC3, 1'b1, 1'b1);
    check("R2 byte C3", rx_byte, 8'hC3);
    check("R2 mp 1", rx_addr_flag, 1);
    pulse_rd();
  endtask

  task automatic t_skip();
    send_frame(8'h12, 1'b0, 1'b1);
    pulse_rd();
    pulse_skip();
    check("R5 armed", skip_en, 1);
    send_frame(8'h77, 1'b0, 1'b0);
    check("R3 byte held", rx_byte, 8'h12);
    check("R3 ready held", rx_ready, 0);
    check("R3 frame err held", err_frame, 0);
    check("R3 overrun held", err_overrun, 0);
    check("R3 mp held", rx_addr_flag, 0);
    check("R3 still armed", skip_en, 1);
    send_frame(8'h31, 1'b1, 1'b1);
    check("R4 id byte", rx_byte, 8'h31);
    check("R4 mp set", rx_addr_flag, 1);
    check("R4 disarmed", skip_en, 0);
    check("R4 ready", rx_ready, 1);
    pulse_rd();
    send_frame(8'h44, 1'b0, 1'b1);
    check("R4 payload after id", rx_byte, 8'h44);
    check("R4 payload mp", rx_addr_flag, 0);
    pulse_rd();
  endtask

  task automatic t_frame_err();
    send_frame(8'h3C, 1'b0, 1'b0);
    repeat (2 * BITCLK) @(negedge clk);
    check("R6 byte kept", rx_byte, 8'h3C);
    check("R6 err set", err_frame, 1);
    pulse_rd();
    send_frame(8'h81, 1'b0, 1'b1);
    check("R6 err cleared", err_frame, 0);
    check("R6 byte 81", rx_byte, 8'h81);
    pulse_rd();
  endtask

  task automatic t_overrun();
    send_frame(8'hA1, 1'b0, 1'b1);
    check("R7 no overrun yet", err_overrun, 0);
    send_frame(8'hA2, 1'b0, 1'b1);
    check("R7 overrun", err_overrun, 1);
    check("R7 newest kept", rx_byte, 8'hA2);
    pulse_rd();
    check("R7 overrun cleared", err_overrun, 0);
    check("R7 ready cleared", rx_ready, 0);
  endtask

  task automatic t_glitch();
    line = 1'b0;
    repeat (12) @(negedge clk);
    line = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    check("R8 no ready", rx_ready, 0);
    check("R8 no frame err", err_frame, 0);
    check("R8 byte held", rx_byte, 8'hA2);
    send_frame(8'h6E, 1'b0, 1'b1);
    check("R8 recovers", rx_byte, 8'h6E);
    pulse_rd();
  endtask

  task automatic tx_send(logic [7:0] d, logic mp, output int busy_clocks);
    tx_byte = d; tx_addr_flag = mp; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    busy_clocks = 0;
    while (tx_busy) begin
      busy_clocks++;
      @(negedge clk);
    end
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic t_tx();
    int n;
    loop = 1'b1;
    pulse_skip();
    tx_send(8'h55, 1'b0, n);
    check("R9 hidden payload", rx_ready, 0);
    tx_send(8'h01, 1'b1, n);
    check("R9 busy length", (n >= 11*BITCLK-8 && n <= 11*BITCLK+8), 1);
    check("R9 id byte", rx_byte, 8'h01);
    check("R9 id mp", rx_addr_flag, 1);
    check("R9 skip cleared", skip_en, 0);
    pulse_rd();
    tx_send(8'hAA, 1'b0, n);
    check("R9 payload AA", rx_byte, 8'hAA);
    check("R9 payload mp", rx_addr_flag, 0);
    check("R9 idle high", txd, 1);
    pulse_rd();
    loop = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_skip();
    t_frame_err();
    t_overrun();
    t_glitch();
    t_tx();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule